// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects every interrupt request of a small fixed-point processor core and reduces them to a single registered vector for the program sequencer. It handles twelve priority slots. The top two slots, the reset request and a power-down request, cannot be masked. The other ten slots are fed by six active-low external pins and by internal request pulses: timer, byte DMA, and two serial-port transmit/receive pairs. Software can also raise any internal slot through a set register.

Configuration is written through a small register port. The port holds a mask word, a control word and a software-set strobe. The control word turns all maskable slots on or off at once. It picks nested or sequential servicing, chooses level or edge sensing for the three programmable pins, and decides whether the second serial port's two slots are driven by its internal requests or by two external pins.

The sequencer takes a presented vector by pulsing `irq_ack` while `irq_valid` is high. It signals the end of a service routine with `irq_ret`. Each taken slot is pushed onto a small priority stack. That stack decides which slots may preempt in nested mode, and it blocks all maskable slots in sequential mode.

Top module: `vec_irq_ctrl`

## Requirements
- R1: When several slots are eligible, the one with the lowest slot index is presented. Slot indices, from highest priority down: 0 reset request, 1 power-down, 2 `irq2_n`, 3 `irql1_n`, 4 `irql0_n`, 5 serial-0 transmit, 6 serial-0 receive, 7 `irqe_n`, 8 byte DMA, 9 serial-1 transmit or `irq1_n`, 10 serial-1 receive or `irq0_n`, 11 timer.
- R2: The presented vector is 0x0000 for slot 0 and 0x002C for slot 1. For any slot k from 2 to 11, the vector is 4*(k-1), so slot 2 gives 0x0004 and slot 11 gives 0x0028.
- R3: A slot k of 2 or above is presented only when two conditions hold. Mask bit k-2 (register address 0; 1 means enabled) must be set, and the global enable (control register, address 1, bit 0) must be 1. Slots 0 and 1 ignore both.
- R4: Control bits 2, 3 and 4 select edge (1) or level (0) sensing for `irq2_n`, `irq1_n` and `irq0_n`. In edge mode, a falling edge is held pending after the pin returns high. In level mode, the request follows the pin, and a short pulse that has ended leaves nothing pending.
- R5: `irql1_n` and `irql0_n` are always level-sensitive. `irqe_n` is always edge-sensitive and latches on a falling edge.
- R6: In nested mode (control bit 1 = 1), a maskable slot is presented while a routine is active only if its index is lower than the active slot. Each `irq_ret` restores the previously active slot.
- R7: In sequential mode (control bit 1 = 0), no maskable slot is presented while any taken routine has not yet returned.
- R8: Control bit 5 = 0 feeds slots 9 and 10 from `int_req[4]` and `int_req[5]`. Control bit 5 = 1 feeds them from `irq1_n` and `irq0_n` instead, and the internal requests are then not seen.
- R9: Writing register address 2 with bit j = 1 sets the request latch of slot j+2, but only for the internal slots 5, 6, 8, 9, 10 and 11. Such writes have no effect on the other slots.
- R10: An acknowledge clears the taken slot's edge or internal latch. `irq_valid` is low in the cycle after an acknowledge.
- R11: After reset, `irq_valid` is low and all maskable slots are masked and globally disabled.
- R12: Taking the reset slot empties the active-routine stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | 0 mask, 1 control, 2 software set |
| cfg_wdata | input | 10 | Register write data |
| reset_req | input | 1 | Reset request, level, slot 0 |
| pwrdn_req | input | 1 | Power-down request, latched on rising edge, slot 1 |
| irq2_n | input | 1 | External pin, programmable sense, slot 2 |
| irql1_n | input | 1 | External pin, level, slot 3 |
| irql0_n | input | 1 | External pin, level, slot 4 |
| irqe_n | input | 1 | External pin, edge, slot 7 |
| irq1_n | input | 1 | External pin, programmable sense, slot 9 in pin mode |
| irq0_n | input | 1 | External pin, programmable sense, slot 10 in pin mode |
| int_req | input | 6 | Internal pulses: 0 timer, 1 byte DMA, 2 serial-0 tx, 3 serial-0 rx, 4 serial-1 tx, 5 serial-1 rx |
| irq_ack | input | 1 | Sequencer takes the presented vector |
| irq_ret | input | 1 | Return from the active routine |
| irq_valid | output | 1 | A vector is presented |
| irq_vec | output | 14 | Vector address |
| irq_src | output | 4 | Slot index of the presented vector |

## Verification
The bench targets preemption. A nested controller that compared priorities with the wrong sign would let a lower slot interrupt an active routine, and one that failed to restore the stack on return would either never re-present a waiting request or present it too early. In sequential mode the bench holds a higher-priority pin while a routine is active: a controller that ignored the active depth would present it.

Short pulses on the programmable pins are sent in both level and edge mode. A controller that latched in level mode, or failed to latch in edge mode, would show the wrong pending state once the pin is high again. The bench also covers three further faults:
- software-set writes aimed at non-internal slots, which a faulty design would fire;
- the serial-1 pin-mode switch, which a faulty design would feed from the wrong source;
- a reset take, after which a stale stack would keep sequential mode blocked.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
  localparam int NSLOT  = 12;
  localparam int SLOT_W = 4;
  localparam int VEC_W  = 14;
  localparam int NMASK  = NSLOT - 2;
  localparam int NPIN   = 6;
  localparam int NINT   = 6;

  localparam int SLOT_RST = 0;
  localparam int SLOT_PD  = 1;
  localparam int SLOT_S0T = 5;
  localparam int SLOT_S0R = 6;
  localparam int SLOT_DMA = 8;
  localparam int SLOT_S1T = 9;
  localparam int SLOT_S1R = 10;
  localparam int SLOT_TMR = 11;

  // slots that software may raise: 5,6,8,9,10,11
  localparam logic [NSLOT-1:0] SOFT_OK = 12'b1111_0110_0000;

  typedef enum logic [1:0] {SENSE_LEVEL, SENSE_EDGE, SENSE_PROG} sense_e;

  typedef struct packed {
    logic pin_mode;
    logic edge0;
    logic edge1;
    logic edge2;
    logic nested;
    logic gie;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  function automatic logic [VEC_W-1:0] slot_vec(input logic [SLOT_W-1:0] s);
    logic [SLOT_W+1:0] v;
    if (s == SLOT_W'(SLOT_RST)) return '0;
    if (s == SLOT_W'(SLOT_PD))  return VEC_W'(16'h002C);
    v = {s - SLOT_W'(1), 2'b00};
    return VEC_W'(v);
  endfunction
endpackage

// File: rtl/vec_irq_sense.sv
module vec_irq_sense
  import vec_irq_pkg::*;
#(
  parameter sense_e KIND = SENSE_PROG,
  parameter int     SYNC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  input  logic edge_sel,
  input  logic clr,
  output logic pend
);
  logic [SYNC-1:0] sy;
  logic            prev;
  logic            hit;
  logic            use_edge;
  logic            fall;

  assign use_edge = (KIND == SENSE_EDGE) | ((KIND == SENSE_PROG) & edge_sel);
  assign fall     = prev & ~sy[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sy   <= '1;
      prev <= 1'b1;
      hit  <= 1'b0;
    end else begin
      sy   <= {sy[SYNC-2:0], pin_n};
      prev <= sy[SYNC-1];
      hit  <= use_edge & (fall | (hit & ~clr));
    end
  end

  assign pend = use_edge ? hit : ~sy[SYNC-1];
endmodule

// File: rtl/vec_irq_prio.sv
module vec_irq_prio
  import vec_irq_pkg::*;
(
  input  logic [NSLOT-1:0]  elig,
  output logic              win_v,
  output logic [SLOT_W-1:0] win_s
);
  always_comb begin
    win_v = |elig;
    win_s = '0;
    for (int i = NSLOT - 1; i >= 0; i--) begin
      if (elig[i]) win_s = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/vec_irq_stack.sv
module vec_irq_stack #(
  parameter int DEPTH  = 4,
  parameter int SLOT_W = 4,
  parameter int IDLE   = 12,
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [SLOT_W-1:0] push_slot,
  input  logic              pop,
  input  logic              flush,
  output logic              full,
  output logic              empty,
  output logic [SLOT_W-1:0] top,
  output logic [DW-1:0]     depth
);
  logic [SLOT_W-1:0] mem [DEPTH];
  logic [DW-1:0]     depth_q;
  logic              pop_ok;
  logic              push_ok;
  logic [DW-1:0]     wr_pos;

  assign empty   = (depth_q == '0);
  assign full    = (depth_q == DW'(DEPTH));
  assign pop_ok  = pop & ~empty;
  assign push_ok = push & (~full | pop_ok);
  assign wr_pos  = depth_q - DW'(pop_ok);

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[AW'(wr_pos)] <= push_slot;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) depth_q <= '0;
    else              depth_q <= depth_q - DW'(pop_ok) + DW'(push_ok);
  end

  assign top   = empty ? SLOT_W'(IDLE) : mem[AW'(depth_q - DW'(1))];
  assign depth = depth_q;
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int STACK_DEPTH = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [NMASK-1:0]  cfg_wdata,
  input  logic              reset_req,
  input  logic              pwrdn_req,
  input  logic              irq2_n,
  input  logic              irql1_n,
  input  logic              irql0_n,
  input  logic              irqe_n,
  input  logic              irq1_n,
  input  logic              irq0_n,
  input  logic [NINT-1:0]   int_req,
  input  logic              irq_ack,
  input  logic              irq_ret,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vec,
  output logic [SLOT_W-1:0] irq_src
);
  localparam int PIN_SLOT [NPIN] = '{2, 3, 4, 7, 9, 10};
  localparam sense_e PIN_KIND [NPIN] =
    '{SENSE_PROG, SENSE_LEVEL, SENSE_LEVEL, SENSE_EDGE, SENSE_PROG, SENSE_PROG};

  // configuration registers
  logic [NMASK-1:0] mask_q;
  ctl_t             ctl_q;
  logic             gie_w, nested_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      ctl_q  <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == 2'd0) mask_q <= cfg_wdata;
      if (cfg_addr == 2'd1) ctl_q  <= ctl_t'(cfg_wdata[CTL_W-1:0]);
    end
  end

  assign gie_w    = ctl_q.gie;
  assign nested_w = ctl_q.nested;

  // output registers and take decode
  logic              valid_q;
  logic [VEC_W-1:0]  vec_q;
  logic [SLOT_W-1:0] src_q;
  logic              take;
  logic [NSLOT-1:0]  take_hot;

  assign take     = irq_ack & valid_q;
  assign take_hot = take ? (NSLOT'(1) << src_q) : '0;

  // external pin sensing
  logic [NPIN-1:0] ext_n;
  logic [NPIN-1:0] pin_edge;
  logic [NPIN-1:0] pin_pend;

  assign ext_n    = {irq0_n, irq1_n, irqe_n, irql0_n, irql1_n, irq2_n};
  assign pin_edge = {ctl_q.edge0, ctl_q.edge1, 3'b000, ctl_q.edge2};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    vec_irq_sense #(
      .KIND (PIN_KIND[g]),
      .SYNC (SYNC_STAGES)
    ) u_sense (
      .clk      (clk),
      .rst      (rst),
      .pin_n    (ext_n[g]),
      .edge_sel (pin_edge[g]),
      .clr      (take_hot[PIN_SLOT[g]]),
      .pend     (pin_pend[g])
    );
  end

  // internal and software request latches
  logic [NSLOT-1:0] int_set;
  logic [NSLOT-1:0] int_lat;

  always_comb begin
    int_set           = '0;
    int_set[SLOT_TMR] = int_req[0];
    int_set[SLOT_DMA] = int_req[1];
    int_set[SLOT_S0T] = int_req[2];
    int_set[SLOT_S0R] = int_req[3];
    int_set[SLOT_S1T] = int_req[4];
    int_set[SLOT_S1R] = int_req[5];
    if (cfg_we && cfg_addr == 2'd2) int_set = int_set | {cfg_wdata, 2'b00};
  end

  always_ff @(posedge clk) begin
    if (rst) int_lat <= '0;
    else     int_lat <= (int_set | (int_lat & ~take_hot)) & SOFT_OK;
  end

  // power-down request latch
  logic pd_prev, pd_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_prev <= 1'b0;
      pd_lat  <= 1'b0;
    end else begin
      pd_prev <= pwrdn_req;
      pd_lat  <= (pwrdn_req & ~pd_prev) | (pd_lat & ~take_hot[SLOT_PD]);
    end
  end

  // pending vector in slot order
  logic [NSLOT-1:0] pend;

  always_comb begin
    pend            = int_lat;
    pend[SLOT_RST]  = reset_req;
    pend[SLOT_PD]   = pd_lat;
    pend[2]         = pin_pend[0];
    pend[3]         = pin_pend[1];
    pend[4]         = pin_pend[2];
    pend[7]         = pin_pend[3];
    pend[SLOT_S1T]  = ctl_q.pin_mode ? pin_pend[4] : int_lat[SLOT_S1T];
    pend[SLOT_S1R]  = ctl_q.pin_mode ? pin_pend[5] : int_lat[SLOT_S1R];
  end

  // active-level stack
  logic              act_full, act_empty;
  logic [SLOT_W-1:0] act_top;
  logic [DEPTH_W-1:0] act_depth;

  vec_irq_stack #(
    .DEPTH  (STACK_DEPTH),
    .SLOT_W (SLOT_W),
    .IDLE   (NSLOT)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (take & (src_q != SLOT_W'(SLOT_RST))),
    .push_slot (src_q),
    .pop       (irq_ret),
    .flush     (take & (src_q == SLOT_W'(SLOT_RST))),
    .full      (act_full),
    .empty     (act_empty),
    .top       (act_top),
    .depth     (act_depth)
  );

  // eligibility
  logic [NSLOT-1:0] elig;

  assign elig[SLOT_RST] = pend[SLOT_RST];
  assign elig[SLOT_PD]  = pend[SLOT_PD] & ~act_full;

  for (genvar k = 2; k < NSLOT; k++) begin : g_elig
    localparam logic [SLOT_W-1:0] KS = SLOT_W'(k);
    assign elig[k] = pend[k] & mask_q[k-2] & ctl_q.gie & ~act_full &
                     (ctl_q.nested ? (KS < act_top) : act_empty);
  end

  logic              win_v;
  logic [SLOT_W-1:0] win_s;

  vec_irq_prio u_prio (
    .elig  (elig),
    .win_v (win_v),
    .win_s (win_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      src_q   <= '0;
    end else begin
      valid_q <= win_v & ~take;
      vec_q   <= slot_vec(win_s);
      src_q   <= win_s;
    end
  end

  assign irq_valid = valid_q;
  assign irq_vec   = vec_q;
  assign irq_src   = src_q;
endmodule

// File: rtl/vec_irq_chk.sv
module vec_irq_chk
  import vec_irq_pkg::*;
#(
  parameter int DW = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              irq_valid,
  input logic              irq_ack,
  input logic [SLOT_W-1:0] irq_src,
  input logic              gie,
  input logic              nested,
  input logic [DW-1:0]     depth,
  input logic [SLOT_W-1:0] top
);
  localparam logic [SLOT_W-1:0] FIRST_MASKABLE = SLOT_W'(2);

  assert_reset_idle_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !irq_valid);

  assert_ack_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack) |=> !irq_valid);

  assert_gie_gate_R3: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src >= FIRST_MASKABLE) |-> $past(gie));

  assert_seq_block_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src >= FIRST_MASKABLE && !$past(nested)) |-> ($past(depth) == '0));

  assert_nest_pri_R6: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_src >= FIRST_MASKABLE && $past(nested) && $past(depth) != '0)
      |-> (irq_src < $past(top)));

  assert_reset_flush_R12: assert property (@(posedge clk) disable iff (rst)
    (irq_valid && irq_ack && irq_src == SLOT_W'(SLOT_RST)) |=> (depth == '0));
endmodule

bind vec_irq_ctrl vec_irq_chk #(.DW(DEPTH_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .irq_valid (irq_valid),
  .irq_ack   (irq_ack),
  .irq_src   (irq_src),
  .gie       (gie_w),
  .nested    (nested_w),
  .depth     (act_depth),
  .top       (act_top)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  logic       reset_req = 1'b0, pwrdn_req = 1'b0;
  logic       irq2_n = 1'b1, irql1_n = 1'b1, irql0_n = 1'b1;
  logic       irqe_n = 1'b1, irq1_n = 1'b1, irq0_n = 1'b1;
  logic [5:0] int_req = '0;
  logic       irq_ack = 1'b0, irq_ret = 1'b0;
  logic       irq_valid;
  logic [13:0] irq_vec;
  logic [3:0] irq_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .reset_req(reset_req), .pwrdn_req(pwrdn_req),
    .irq2_n(irq2_n), .irql1_n(irql1_n), .irql0_n(irql0_n),
    .irqe_n(irqe_n), .irq1_n(irq1_n), .irq0_n(irq0_n),
    .int_req(int_req), .irq_ack(irq_ack), .irq_ret(irq_ret),
    .irq_valid(irq_valid), .irq_vec(irq_vec), .irq_src(irq_src)
  );

  function automatic int exp_vec(input int s);
    if (s == 0) return 0;
    if (s == 1) return 'h2C;
    return 4 * (s - 1);
  endfunction

  // winner among level pins: lv bits = {irq0,irq1,l0,l1,irq2} low
  function automatic int exp_level_win(input logic [9:0] m, input logic [4:0] lv);
    int sl [5] = '{2, 3, 4, 9, 10};
    for (int i = 0; i < 5; i++)
      if (lv[i] && m[sl[i]-2]) return sl[i];
    return -1;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic ret();
    @(negedge clk); irq_ret = 1'b1;
    @(negedge clk); irq_ret = 1'b0;
  endtask

  task automatic expect_slot(input string tag, input int s);
    chk({tag, " valid"}, int'(irq_valid), 1);
    chk({tag, " src"}, int'(irq_src), s);
    chk({tag, " vec"}, int'(irq_vec), exp_vec(s));
  endtask

  task automatic expect_none(input string tag);
    chk({tag, " idle"}, int'(irq_valid), 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    rst = 1'b0;
    tick(1);
    expect_none("R11 reset");

    // R11: everything masked after reset
    irql0_n = 1'b0; tick(6);
    expect_none("R11 masked after reset");
    irql0_n = 1'b1; tick(4);

    // reset request vector (R1, R2)
    reset_req = 1'b1; tick(3);
    expect_slot("R2 reset vector", 0);
    ack(); reset_req = 1'b0;
    expect_none("R10 drop after ack");
    tick(3); expect_none("R10 reset request gone");

    // power-down bypasses mask and enable (R3, R2)
    pwrdn_req = 1'b1; tick(3);
    expect_slot("R3 power-down unmaskable", 1);
    ack(); pwrdn_req = 1'b0; tick(3);
    expect_none("R10 power-down latch cleared");
    ret();

    // enable, unmask all, sequential, all level
    wr(2'd1, 10'b00_0000_0001);
    wr(2'd0, 10'h3FF);
    irql0_n = 1'b0; tick(6);
    expect_slot("R5 level l0", 4);
    irql1_n = 1'b0; tick(6);
    expect_slot("R1 l1 over l0", 3);
    irql0_n = 1'b1; irql1_n = 1'b1; tick(6);
    expect_none("R5 level released");

    // fixed edge pin
    irqe_n = 1'b0; tick(1); irqe_n = 1'b1; tick(6);
    expect_slot("R5 edge held", 7);
    ack();
    expect_none("R10 drop after edge ack");
    tick(4); expect_none("R10 edge latch cleared");
    ret();

    // programmable pin: level then edge (R4)
    irq2_n = 1'b0; tick(1); irq2_n = 1'b1; tick(6);
    expect_none("R4 level pulse gone");
    wr(2'd1, 10'b00_0000_0101);
    irq2_n = 1'b0; tick(1); irq2_n = 1'b1; tick(6);
    expect_slot("R4 edge latched", 2);
    ack(); tick(4);
    expect_none("R4 edge cleared by ack");
    ret();

    // masking and global enable (R3)
    wr(2'd0, 10'h3FF & ~10'h004);
    irql0_n = 1'b0; tick(6);
    expect_none("R3 mask bit blocks");
    wr(2'd0, 10'h3FF); tick(4);
    expect_slot("R3 unmasked", 4);
    wr(2'd1, 10'b00_0000_0100); tick(4);
    expect_none("R3 global disable");
    wr(2'd1, 10'b00_0000_0101); tick(4);

    // sequential servicing (R7)
    expect_slot("R7 first take", 4);
    ack();
    irql1_n = 1'b0; tick(6);
    expect_none("R7 no preempt");
    ret(); tick(3);
    expect_slot("R7 after return", 3);
    irql1_n = 1'b1; irql0_n = 1'b1; tick(6);
    expect_none("R7 released");

    // nested servicing (R6)
    wr(2'd1, 10'b00_0000_0111);
    irql0_n = 1'b0; tick(6);
    expect_slot("R6 base", 4);
    ack(); tick(3);
    expect_none("R6 same level blocked");
    irql1_n = 1'b0; tick(6);
    expect_slot("R6 preempt", 3);
    ack();
    irql1_n = 1'b1; tick(6);
    expect_none("R6 lower blocked at depth 2");
    ret(); tick(3);
    expect_none("R6 restored level blocks");
    ret(); tick(3);
    expect_slot("R6 idle re-presents", 4);
    irql0_n = 1'b1; tick(6);

    // reset take flushes the stack (R12)
    irql0_n = 1'b0; tick(6);
    ack();
    irql0_n = 1'b1;
    reset_req = 1'b1; tick(3);
    expect_slot("R12 reset presented", 0);
    ack(); reset_req = 1'b0;
    wr(2'd1, 10'b00_0000_0101);
    irql1_n = 1'b0; tick(6);
    expect_slot("R12 stack emptied", 3);
    irql1_n = 1'b1; tick(6);

    // serial-1 slot source selection (R8)
    irq1_n = 1'b0; tick(6);
    expect_none("R8 pin ignored in internal mode");
    @(negedge clk); int_req[4] = 1'b1;
    @(negedge clk); int_req[4] = 1'b0;
    tick(2);
    expect_slot("R8 internal request", 9);
    ack(); ret();
    wr(2'd1, 10'b00_0010_0101); tick(6);
    expect_slot("R8 pin mode", 9);
    irq1_n = 1'b1; tick(6);
    irq0_n = 1'b0; tick(6);
    expect_slot("R8 pin mode irq0", 10);
    irq0_n = 1'b1; tick(6);
    @(negedge clk); int_req[5] = 1'b1;
    @(negedge clk); int_req[5] = 1'b0;
    tick(3);
    expect_none("R8 internal hidden in pin mode");

    // software set (R9)
    wr(2'd2, 10'b10_0000_0000); tick(3);
    expect_slot("R9 soft timer", 11);
    ack(); ret();
    wr(2'd2, 10'b00_0010_0001); tick(4);
    expect_none("R9 non-internal slots ignored");
    wr(2'd2, 10'b00_0000_1000); tick(3);
    expect_slot("R9 soft serial-0 tx", 5);
    ack(); ret(); tick(3);
    expect_none("R9 soft latch cleared");

    // random level patterns (R1, R3, R2)
    wr(2'd1, 10'b00_0010_0001);
    for (int it = 0; it < 24; it++) begin
      logic [9:0] m;
      logic [4:0] lv;
      int w;
      m  = 10'($urandom);
      lv = 5'($urandom);
      irq2_n = ~lv[0]; irql1_n = ~lv[1]; irql0_n = ~lv[2];
      irq1_n = ~lv[3]; irq0_n = ~lv[4];
      wr(2'd0, m);
      tick(6);
      w = exp_level_win(m, lv);
      if (w < 0) expect_none("R3 random none");
      else       expect_slot("R1 random winner", w);
    end
    irq2_n = 1'b1; irql1_n = 1'b1; irql0_n = 1'b1; irq1_n = 1'b1; irq0_n = 1'b1;
    tick(6);
    expect_none("R1 final idle");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule